// File: doc/BRIEF.md
# System Protection Watchdog with Bus Timeout Monitor

This block guards a processor subsystem in two ways. The watchdog counts system clocks once it is enabled. Software must restart the count before it reaches the selected timeout by writing a two-byte key to the service register. If the key does not arrive in time, the block does one of two things, chosen by the control register. It can raise a high-priority interrupt request, which goes with a programmable vector number. Or it can raise a system reset request, which it holds for the reset generator. The bus timeout monitor watches each bus transfer from its start strobe to its acknowledge. If the acknowledge is too late, it pulses a bus error.

Software reaches the block through a byte-wide register port with four locations: control, service, vector and reset status. The control register takes one write only after each reset, so a runaway program cannot turn protection off. The reset status register records whether the last reset was an external hard reset or a reset that the watchdog caused. It keeps this record through the system reset that follows a watchdog timeout. The asynchronous active-low input is the external hard reset. The synchronous active-high input is the system reset that the reset generator applies. That second input clears everything except the reset status.

Top module: `sysprot_wdt`

## Requirements
- R1: Register address 0 is the control register. The first write to it after either reset is stored and can be read back. Every later write is ignored until the next reset, including a write of 0x00.
- R2: Control bit 7 enables the watchdog. Control bit 6 selects the timeout action: 0 raises `irq_req` and 1 raises `rst_req`. Only one of the two outputs is ever asserted.
- R3: Control bits 4:3 (value s) and bit 5 (prescale) set the timeout T. T is 2^(TS_BASE_LOG2 + 2s) clocks, multiplied by 2^PRESCALE_LOG2 when bit 5 is set. The action output rises exactly T clocks after the clock edge that completes a service sequence.
- R4: Writing 0x55 to address 1 arms the service sequence. A following write of 0xAA to address 1 restarts the count. A different value disarms the sequence without a restart. A write of 0xAA with no armed 0x55 has no effect.
- R5: While control bit 7 is 0, the watchdog count stays at zero and neither action output is raised.
- R6: In interrupt mode, `irq_req` stays high until a service sequence completes or `irq_ack` is sampled high. Either one clears it on the next edge.
- R7: In reset mode, `rst_req` stays high until `sys_rst`. At the edge where it rises, the reset status register (address 3) becomes 0x20.
- R8: Address 2 is the vector register. It resets to 0x0F, can be read back, and drives `irq_vector`.
- R9: The hard reset `rst_n` sets the reset status to 0x80. `sys_rst` leaves it unchanged. A write of 0x00 to address 3 clears it, and a nonzero write is ignored.
- R10: Control bit 2 enables the bus monitor. Bits 1:0 (value b) set the limit L = 2^(BM_BASE_LOG2 - b) clocks. If `bus_start` is seen and no `bus_ack` follows, `bus_err` is high for exactly one cycle, L clocks after the start edge. With bit 2 clear, no error is raised.
- R11: A `bus_ack` ends the pending transfer and clears its count. No bus error follows for that transfer.
- R12: `sys_rst` clears the control register and its write lock, the service arming and the vector. The control register is then writable once again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hard reset, asynchronous assert, active low |
| sys_rst | input | 1 | System reset from the reset generator, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address, used for both read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_req | output | 1 | Watchdog interrupt request |
| irq_vector | output | 8 | Vector number supplied with the interrupt |
| rst_req | output | 1 | Watchdog system reset request |
| bus_start | input | 1 | Bus transfer start strobe |
| bus_ack | input | 1 | Bus transfer acknowledge |
| bus_err | output | 1 | One-cycle bus timeout error |

## Verification
Suppose the count or prescaler is in a wrong state. The action output then rises one or more clocks away from the exact edge the timeout table predicts. Each configuration is therefore checked one clock before and at that edge. A wrong key-sequence state shows up as an early or missed restart, which moves the timeout edge by tens of clocks. A broken write lock shows in the very next control read-back. If the bus monitor's pending or count state is wrong, `bus_err` appears off its L-clock edge, lasts two cycles, or appears after an acknowledge.

// File: rtl/sysprot_wdt_pkg.sv
package sysprot_wdt_pkg;
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_SVC  = 2'd1;
  localparam logic [1:0] ADR_VEC  = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  localparam logic [7:0] VEC_RESET   = 8'h0F;
  localparam logic [7:0] STAT_HARD   = 8'h80;
  localparam logic [7:0] STAT_WDOG   = 8'h20;

  typedef struct packed {
    logic       wd_en;
    logic       act_rst;
    logic       psel;
    logic [1:0] tsel;
    logic       bm_en;
    logic [1:0] bm_sel;
  } ctrl_t;
endpackage

// File: rtl/sysprot_wdt_regs.sv
module sysprot_wdt_regs
  import sysprot_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  input  logic       fire_rst,
  output logic [7:0] rd_data,
  output ctrl_t      ctrl_o,
  output logic       kick,
  output logic [7:0] vec_o
);
  ctrl_t      ctrl_q, ctrl_d;
  logic       lock_q, lock_d;
  logic       arm_q, arm_d;
  logic [7:0] vec_q, vec_d;
  logic [7:0] stat_q, stat_d;
  logic       wr_ctrl, wr_svc, wr_vec, wr_stat;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADR_CTRL);
    wr_svc  = wr_en && (addr == ADR_SVC);
    wr_vec  = wr_en && (addr == ADR_VEC);
    wr_stat = wr_en && (addr == ADR_STAT);

    ctrl_d = ctrl_q;
    lock_d = lock_q;
    if (wr_ctrl && !lock_q) begin
      ctrl_d = ctrl_t'(wr_data);
      lock_d = 1'b1;
    end

    kick  = 1'b0;
    arm_d = arm_q;
    if (wr_svc) begin
      if (wr_data == KEY_ARM) begin
        arm_d = 1'b1;
      end else begin
        arm_d = 1'b0;
        kick  = arm_q && (wr_data == KEY_FIRE);
      end
    end

    vec_d = wr_vec ? wr_data : vec_q;

    stat_d = stat_q;
    if (fire_rst)
      stat_d = STAT_WDOG;
    else if (wr_stat && (wr_data == 8'h00))
      stat_d = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      arm_q  <= 1'b0;
      vec_q  <= VEC_RESET;
    end else if (sys_rst) begin
      ctrl_q <= '0;
      lock_q <= 1'b0;
      arm_q  <= 1'b0;
      vec_q  <= VEC_RESET;
    end else begin
      ctrl_q <= ctrl_d;
      lock_q <= lock_d;
      arm_q  <= arm_d;
      vec_q  <= vec_d;
    end
  end

  // status survives sys_rst on purpose
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_HARD;
    else        stat_q <= stat_d;
  end

  always_comb begin
    case (addr)
      ADR_CTRL: rd_data = ctrl_q;
      ADR_VEC:  rd_data = vec_q;
      ADR_STAT: rd_data = stat_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign vec_o  = vec_q;

  a_r1_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !sys_rst) |=> (ctrl_q == $past(ctrl_q)));

  a_r9_stat_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && !fire_rst && !wr_stat) |=> (stat_q == $past(stat_q)));
endmodule

// File: rtl/sysprot_wdt_timer.sv
module sysprot_wdt_timer #(
  parameter int TS_BASE_LOG2  = 9,
  parameter int PRESCALE_LOG2 = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       en,
  input  logic       act_rst,
  input  logic       psel,
  input  logic [1:0] tsel,
  input  logic       kick,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic       rst_req,
  output logic       fire_rst
);
  localparam int CNT_W = TS_BASE_LOG2 + 6;
  localparam int SH_W  = $clog2(CNT_W + 1);
  localparam int PRE_W = PRESCALE_LOG2;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             irq_q, irq_d, rsq_q, rsq_d;
  logic [SH_W-1:0]  shamt;
  logic             tick, fire;

  always_comb begin
    shamt  = SH_W'(TS_BASE_LOG2) + SH_W'({tsel, 1'b0});
    lim_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
    tick   = !psel || (pre_q == '1);
    fire   = 1'b0;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    irq_d  = irq_q;
    rsq_d  = rsq_q;
    if (!en) begin
      cnt_d = '0;
      pre_d = '0;
      irq_d = 1'b0;
    end else if (kick) begin
      cnt_d = '0;
      pre_d = '0;
      irq_d = 1'b0;
    end else begin
      if (irq_ack) irq_d = 1'b0;
      if (!rsq_q) begin
        if (psel) pre_d = pre_q + PRE_W'(1);
        if (tick) begin
          if (cnt_q == lim_m1) begin
            cnt_d = '0;
            fire  = 1'b1;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      if (fire) begin
        if (act_rst) rsq_d = 1'b1;
        else         irq_d = 1'b1;
      end
    end
    fire_rst = fire && act_rst && !sys_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      irq_q <= 1'b0;
      rsq_q <= 1'b0;
    end else if (sys_rst) begin
      cnt_q <= '0;
      pre_q <= '0;
      irq_q <= 1'b0;
      rsq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pre_q <= pre_d;
      irq_q <= irq_d;
      rsq_q <= rsq_d;
    end
  end

  assign irq_req = irq_q;
  assign rst_req = rsq_q;

  a_r2_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, rsq_q}));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_q);

  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && en && !kick && !irq_ack && !sys_rst) |=> irq_q);

  a_r7_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsq_q && !sys_rst) |=> rsq_q);
endmodule

// File: rtl/sysprot_wdt_busmon.sv
module sysprot_wdt_busmon #(
  parameter int BM_BASE_LOG2 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       en,
  input  logic [1:0] bm_sel,
  input  logic       bus_start,
  input  logic       bus_ack,
  output logic       bus_err
);
  localparam int BM_W = BM_BASE_LOG2;
  localparam int SB_W = $clog2(BM_BASE_LOG2 + 1);

  logic [BM_W-1:0] cnt_q, cnt_d, lim_m1;
  logic [SB_W-1:0] shamt;
  logic            pend_q, pend_d, err_q, err_d;

  always_comb begin
    shamt  = SB_W'(BM_BASE_LOG2) - SB_W'(bm_sel);
    lim_m1 = (BM_W'(1) << shamt) - BM_W'(1);
    cnt_d  = cnt_q;
    pend_d = pend_q;
    err_d  = 1'b0;
    if (!en || bus_ack) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (bus_start) begin
      cnt_d  = '0;
      pend_d = 1'b1;
    end else if (pend_q) begin
      if (cnt_q == lim_m1) begin
        cnt_d  = '0;
        pend_d = 1'b0;
        err_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + BM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (sys_rst) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  assign bus_err = err_q;

  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

  a_r11_ack_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !err_q);
endmodule

// File: rtl/sysprot_wdt.sv
module sysprot_wdt
  import sysprot_wdt_pkg::*;
#(
  parameter int TS_BASE_LOG2  = 9,
  parameter int PRESCALE_LOG2 = 9,
  parameter int BM_BASE_LOG2  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic [7:0] irq_vector,
  output logic       rst_req,
  input  logic       bus_start,
  input  logic       bus_ack,
  output logic       bus_err
);
  ctrl_t ctrl;
  logic  kick, fire_rst;

  sysprot_wdt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .fire_rst(fire_rst), .rd_data(rd_data),
    .ctrl_o(ctrl), .kick(kick), .vec_o(irq_vector)
  );

  sysprot_wdt_timer #(
    .TS_BASE_LOG2(TS_BASE_LOG2), .PRESCALE_LOG2(PRESCALE_LOG2)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .en(ctrl.wd_en), .act_rst(ctrl.act_rst), .psel(ctrl.psel),
    .tsel(ctrl.tsel), .kick(kick), .irq_ack(irq_ack),
    .irq_req(irq_req), .rst_req(rst_req), .fire_rst(fire_rst)
  );

  sysprot_wdt_busmon #(
    .BM_BASE_LOG2(BM_BASE_LOG2)
  ) u_busmon (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
    .en(ctrl.bm_en), .bm_sel(ctrl.bm_sel),
    .bus_start(bus_start), .bus_ack(bus_ack), .bus_err(bus_err)
  );
endmodule

// File: tb/sysprot_wdt_tb.sv
module sysprot_wdt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TSB = 2;
  localparam int PSB = 2;
  localparam int BMB = 4;

  logic       clk, rst_n, sys_rst, wr_en, irq_ack, bus_start, bus_ack;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data, irq_vector;
  logic       irq_req, rst_req, bus_err;
  int n_chk = 0;
  int n_fail = 0;

  sysprot_wdt #(.TS_BASE_LOG2(TSB), .PRESCALE_LOG2(PSB), .BM_BASE_LOG2(BMB)) dut_i (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_vector(irq_vector), .rst_req(rst_req), .bus_start(bus_start),
    .bus_ack(bus_ack), .bus_err(bus_err));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rd_data);
  endtask

  task automatic pulse_sysrst();
    sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
  endtask

  task automatic service();
    wr(2'd1, 8'h55); wr(2'd1, 8'hAA);
  endtask

  function automatic int tmo(input int t);
    int v;
    v = 1 << (TSB + 2 * (t % 4));
    if (t >= 4) v = v << PSB;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, lim, bad;
    rst_n = 1'b0; sys_rst = 1'b0; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
    irq_ack = 1'b0; bus_start = 1'b0; bus_ack = 1'b0;
    step(3); rst_n = 1'b1; step(1);

    // reset state
    rd(2'd0, v); chk(v, 0, "R1 ctrl reset");
    rd(2'd2, v); chk(v, 8'h0F, "R8 vector reset");
    rd(2'd3, v); chk(v, 8'h80, "R9 hard reset status");
    chk({irq_req, rst_req, bus_err}, 0, "R2 outputs idle after reset");

    // write-once lock
    wr(2'd0, 8'h80); wr(2'd0, 8'h00);
    rd(2'd0, v); chk(v, 8'h80, "R1 second ctrl write ignored");
    wr(2'd0, 8'hC4);
    rd(2'd0, v); chk(v, 8'h80, "R1 third ctrl write ignored");

    // timeout sweep: every tsel x both actions
    for (int m = 0; m < 2; m++) begin
      for (int t = 0; t < 8; t++) begin
        pulse_sysrst();
        rd(2'd0, v); chk(v, 0, "R12 ctrl cleared by sys_rst");
        wr(2'd0, 8'(8'h80 | (m << 6) | (t << 3)));
        service();
        step(tmo(t) - 1);
        chk({irq_req, rst_req}, 0, "R3 no action before timeout");
        step(1);
        chk({irq_req, rst_req}, (m == 1) ? 1 : 2, "R3 R2 action at timeout");
        if (m == 1) begin
          rd(2'd3, v); chk(v, 8'h20, "R7 status marks watchdog reset");
          step(5); chk(rst_req, 1, "R7 rst_req held");
          pulse_sysrst();
          chk(rst_req, 0, "R7 rst_req cleared by sys_rst");
          rd(2'd3, v); chk(v, 8'h20, "R9 status kept across sys_rst");
          wr(2'd3, 8'h05);
          rd(2'd3, v); chk(v, 8'h20, "R9 nonzero status write ignored");
          wr(2'd3, 8'h00);
          rd(2'd3, v); chk(v, 0, "R9 status cleared by zero write");
        end else begin
          step(2); chk(irq_req, 1, "R6 irq held");
          irq_ack = 1'b1; step(1); irq_ack = 1'b0;
          chk(irq_req, 0, "R6 irq cleared by ack");
        end
      end
    end

    // service key ordering, T = 64
    pulse_sysrst();
    wr(2'd0, 8'h90);
    service();
    step(30);
    wr(2'd1, 8'h55); wr(2'd1, 8'h12); wr(2'd1, 8'hAA);
    step(30); chk(irq_req, 0, "R4 before original deadline");
    step(1);  chk(irq_req, 1, "R4 broken key did not restart");
    service();
    chk(irq_req, 0, "R6 irq cleared by service");
    step(63); chk(irq_req, 0, "R4 good key restarted count");
    step(1);  chk(irq_req, 1, "R4 timeout after good key");

    // disabled watchdog and bus monitor
    pulse_sysrst();
    wr(2'd0, 8'h00);
    bus_start = 1'b1; step(1); bus_start = 1'b0;
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (irq_req || rst_req || bus_err) bad++;
    end
    chk(bad, 0, "R5 R10 nothing raised while disabled");

    // bus monitor limits
    pulse_sysrst();
    wr(2'd0, 8'h04);
    for (int b = 0; b < 4; b++) begin
      pulse_sysrst();
      wr(2'd0, 8'(8'h04 | b));
      lim = (1 << BMB) >> b;
      bus_start = 1'b1; step(1); bus_start = 1'b0;
      step(lim - 1); chk(bus_err, 0, "R10 no error before limit");
      step(1);       chk(bus_err, 1, "R10 error at limit");
      step(1);       chk(bus_err, 0, "R10 error lasts one cycle");
      bus_start = 1'b1; step(1); bus_start = 1'b0;
      step(lim - 2);
      bus_ack = 1'b1; step(1); bus_ack = 1'b0;
      bad = 0;
      for (int i = 0; i < lim + 2; i++) begin
        step(1);
        if (bus_err) bad++;
      end
      chk(bad, 0, "R11 ack prevents error");
    end

    // vector register
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk(v, 8'h40, "R8 vector readback");
    chk(irq_vector, 8'h40, "R8 vector output");
    pulse_sysrst();
    chk(irq_vector, 8'h0F, "R12 vector cleared by sys_rst");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule